// File: doc/BRIEF.md
# Multiprocessor UART Receive Controller

This block is the receive half of a serial port that carries 9-bit characters: a start bit, eight data bits sent least significant first, a ninth bit, and a stop bit. It watches the serial input line on every tick of an external oversampling strobe, which runs at sixteen times the bit rate. It then samples each bit at its centre and puts the character together in a shift register.

The ninth bit tells an address character (1) from a data character (0). When the address-filter bit is set, the block raises its receive flag only for an address character that matches this node's own masked address or the group-wide broadcast address. Every other character is dropped without any sign to software. When the filter is off, every complete character raises the flag.

A sticky flag records any character whose stop bit was sampled low. The top bit of the control register shows either that flag or a plain mode bit, and a separate select register decides which of the two is seen.

Top module: `mpRxCtrl`

## Requirements
- R1: After reset, every register reads 0 and `ri` is 0. Register offsets: 0 control, 1 view select (bit 0), 2 node address, 3 address mask, 4 receive buffer (read-only). Control register bits: bit 7 mode/error view, bit 5 address filter, bit 2 received ninth bit (read-only), bit 0 receive flag.
- R2: The input line is sampled at the centre of each bit period, 16 ticks per bit. The eight data bits arrive least significant first and are followed by the ninth bit. A character is received correctly at any tick rate.
- R3: A start bit that is no longer low at its centre, 8 ticks after the falling edge, is ignored. No receive flag is raised, and the next valid character is still received.
- R4: With the address filter at 0, every complete character, including one with a bad stop bit, sets `ri`. It also loads the buffer with the data byte and control bit 2 with the ninth bit.
- R5: With the address filter at 1, a character whose ninth bit is 0 leaves `ri`, the buffer and bit 2 unchanged.
- R6: With the address filter at 1 and the ninth bit at 1, the character is accepted when `((byte ^ nodeAddr) & mask) == 0`.
- R7: With the address filter at 1 and the ninth bit at 1, the character is also accepted when `(~byte & (nodeAddr | mask)) == 0`, which is the broadcast match.
- R8: A character whose stop bit is sampled low sets the error flag. The flag stays set through later good characters and through writes of 1. A control write of bit 7 = 0 while the view select is 1 clears it.
- R9: With view select 1, control bit 7 reads and writes the error flag. With view select 0, it reads and writes the mode bit. A write through one view leaves the other bit unchanged.
- R10: `ri` stays set until software writes control bit 0. While `ri` is set, a newly accepted character changes neither the buffer nor bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous |
| baudTick | input | 1 | Oversampling strobe at 16x the bit rate, one clock wide |
| rxLine | input | 1 | Serial input line, high when idle |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for `regAddr`, combinational |
| ri | output | 1 | Receive flag |

## Verification
An exhaustive sweep sends all 256 address bytes with the filter on, using a node address and mask chosen so that the node-address set and the broadcast set are both non-empty and do not overlap. The bench predicts each acceptance from the two match formulas, so a fault in either comparator shows up on its own. Data characters sent under the filter, characters sent with the filter off, a slowed tick, a runt start pulse and a low stop bit separate the filter gate, the bit timing, the false-start check and the framing logic. A second character sent while the flag is still set, together with writes through both views of control bit 7, separates the overrun guard from the shared-bit storage.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

  // register offsets
  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_VSEL = 3'd1;
  localparam logic [2:0] OFS_NODE = 3'd2;
  localparam logic [2:0] OFS_MASK = 3'd3;
  localparam logic [2:0] OFS_RBUF = 3'd4;

  // control register bit positions
  localparam int CB_VIEW = 7;
  localparam int CB_FILT = 5;
  localparam int CB_NINE = 2;
  localparam int CB_RI   = 0;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP
  } rxState_t;

  typedef struct packed {
    logic shiftEn;    // sample the line into the shift register
    logic frameDone;  // stop bit sampled now
  } rxStrobe_t;

endpackage

// File: rtl/mpRxCtrl_ctrl.sv
module mpRxCtrl_ctrl
  import mprx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int NBITS = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      lineNow,
  output rxStrobe_t strb
);

  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(NBITS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             sawHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      sawHigh <= 1'b0;
    end else if (baudTick) begin
      case (state)
        RX_IDLE: begin
          if (lineNow) begin
            sawHigh <= 1'b1;
          end else if (sawHigh) begin
            state   <= RX_START;
            tickCnt <= '0;
            sawHigh <= 1'b0;
          end
        end
        RX_START: begin
          if (tickCnt == CNT_HALF) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= lineNow ? RX_IDLE : RX_BITS;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_BITS: begin
          if (tickCnt == CNT_LAST) begin
            tickCnt <= '0;
            if (bitIdx == BIT_LAST) state <= RX_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: begin
          if (tickCnt == CNT_LAST) begin
            tickCnt <= '0;
            state   <= RX_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strb.shiftEn   = baudTick && (state == RX_BITS) && (tickCnt == CNT_LAST);
    strb.frameDone = baudTick && (state == RX_STOP) && (tickCnt == CNT_LAST);
  end

endmodule

// File: rtl/mpRxCtrl_dp.sv
module mpRxCtrl_dp
  import mprx_pkg::*;
#(
  parameter int DATA_W = 8,   // at least 8: control bits live up to bit 7
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  rxStrobe_t         strb,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              lineNow,
  output logic              riFlag,
  output logic              feFlag,
  output logic              sm0,
  output logic              sm2,
  output logic              selFe,
  output logic              rb8,
  output logic [DATA_W-1:0] rxBuf
);

  logic [SYNC-1:0]   syncQ;
  logic [DATA_W:0]   shReg;
  logic [DATA_W-1:0] nodeAddr;
  logic [DATA_W-1:0] addrMask;
  logic [DATA_W-1:0] rxByte;
  logic              rxNinth;
  logic              givenHit;
  logic              bcastHit;
  logic              accept;
  logic              ctrlWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC-2:0], rxLine};
  end
  assign lineNow = syncQ[SYNC-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shReg <= '0;
    else if (strb.shiftEn) shReg <= {lineNow, shReg[DATA_W:1]};
  end

  assign rxByte   = shReg[DATA_W-1:0];
  assign rxNinth  = shReg[DATA_W];
  assign givenHit = ((rxByte ^ nodeAddr) & addrMask) == '0;
  assign bcastHit = (~rxByte & (nodeAddr | addrMask)) == '0;
  assign accept   = strb.frameDone && (!sm2 || (rxNinth && (givenHit || bcastHit)));
  assign ctrlWr   = regWrEn && (regAddr == OFS_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riFlag   <= 1'b0;
      feFlag   <= 1'b0;
      sm0      <= 1'b0;
      sm2      <= 1'b0;
      selFe    <= 1'b0;
      rb8      <= 1'b0;
      rxBuf    <= '0;
      nodeAddr <= '0;
      addrMask <= '0;
    end else begin
      if (accept)      riFlag <= 1'b1;
      else if (ctrlWr) riFlag <= regWrData[CB_RI];

      if (accept && !riFlag) begin
        rxBuf <= rxByte;
        rb8   <= rxNinth;
      end

      if (strb.frameDone && !lineNow) feFlag <= 1'b1;
      else if (ctrlWr && selFe && !regWrData[CB_VIEW]) feFlag <= 1'b0;

      if (ctrlWr && !selFe) sm0 <= regWrData[CB_VIEW];
      if (ctrlWr)           sm2 <= regWrData[CB_FILT];

      if (regWrEn && regAddr == OFS_VSEL) selFe    <= regWrData[0];
      if (regWrEn && regAddr == OFS_NODE) nodeAddr <= regWrData;
      if (regWrEn && regAddr == OFS_MASK) addrMask <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_CTRL: begin
        regRdData[CB_VIEW] = selFe ? feFlag : sm0;
        regRdData[CB_FILT] = sm2;
        regRdData[CB_NINE] = rb8;
        regRdData[CB_RI]   = riFlag;
      end
      OFS_VSEL: regRdData[0] = selFe;
      OFS_NODE: regRdData = nodeAddr;
      OFS_MASK: regRdData = addrMask;
      OFS_RBUF: regRdData = rxBuf;
      default:  regRdData = '0;
    endcase
  end

endmodule

// File: rtl/mpRxCtrl.sv
module mpRxCtrl
  import mprx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              rxLine,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              ri
);

  localparam int NBITS = DATA_W + 1;

  rxStrobe_t         strb;
  logic              lineNow;
  logic              feFlag;
  logic              sm0;
  logic              sm2;
  logic              selFe;
  logic              rb8;
  logic [DATA_W-1:0] rxBuf;

  mpRxCtrl_ctrl #(.OVS(OVS), .NBITS(NBITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .lineNow  (lineNow),
    .strb     (strb)
  );

  mpRxCtrl_dp #(.DATA_W(DATA_W), .SYNC(SYNC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxLine    (rxLine),
    .strb      (strb),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .lineNow   (lineNow),
    .riFlag    (ri),
    .feFlag    (feFlag),
    .sm0       (sm0),
    .sm2       (sm2),
    .selFe     (selFe),
    .rb8       (rb8),
    .rxBuf     (rxBuf)
  );

endmodule

// File: rtl/mpRxCtrl_chk.sv
module mpRxCtrl_chk
  import mprx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [2:0]        regAddr,
  input logic              ri,
  input logic              feFlag,
  input logic              sm0,
  input logic              sm2,
  input logic              selFe,
  input logic              rb8,
  input logic [DATA_W-1:0] rxBuf,
  input rxStrobe_t         strb
);

  logic ctrlWr;
  assign ctrlWr = regWrEn && (regAddr == OFS_CTRL);

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftEn, strb.frameDone}));

  assert_filter_ninth_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ri) && !$past(ctrlWr) && $past(sm2)) |-> rb8);

  assert_fe_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (feFlag && !(ctrlWr && selFe)) |=> feFlag);

  assert_view_keeps_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && selFe) |=> $stable(sm0));

  assert_ri_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ri && !ctrlWr) |=> ri);

  assert_buf_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    ri |=> ($stable(rxBuf) && $stable(rb8)));

endmodule

bind mpRxCtrl mpRxCtrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regWrEn (regWrEn),
  .regAddr (regAddr),
  .ri      (ri),
  .feFlag  (feFlag),
  .sm0     (sm0),
  .sm2     (sm2),
  .selFe   (selFe),
  .rb8     (rb8),
  .rxBuf   (rxBuf),
  .strb    (strb)
);

// File: tb/tb_mpRxCtrl.sv
module tb_mpRxCtrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       ri;

  int checks = 0;
  int errors = 0;
  int tickDiv = 1;
  int tickCnt = 0;

  mpRxCtrl dut (
    .clk       (clk),
    .rstN      (rstN),
    .baudTick  (baudTick),
    .rxLine    (rxLine),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .ri        (ri)
  );

  always #10 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      if (tickCnt >= tickDiv - 1) begin
        tickCnt  = 0;
        baudTick = 1'b1;
      end else begin
        tickCnt  = tickCnt + 1;
        baudTick = 1'b0;
      end
    end
  end

  task automatic checkEq(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic holdBits(input int n);
    repeat (n * 16 * tickDiv) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic ninth, input logic stopBit);
    @(negedge clk);
    rxLine = 1'b0; holdBits(1);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i]; holdBits(1);
    end
    rxLine = ninth;   holdBits(1);
    rxLine = stopBit; holdBits(1);
    rxLine = 1'b1;
    repeat (3 * tickDiv * 16) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] sa;
    logic [7:0] mk;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      checkEq("R1 reg after reset", v, 8'h00);
    end
    checkEq("R1 ri after reset", {7'd0, ri}, 8'h00);

    // R4: filter off, data and address characters
    sendFrame(8'hA5, 1'b0, 1'b1);
    rd(3'd0, v); checkEq("R4 ri", {7'd0, v[0]}, 8'h01);
    checkEq("R4 ninth", {7'd0, v[2]}, 8'h00);
    rd(3'd4, v); checkEq("R4 buf", v, 8'hA5);
    wr(3'd0, 8'h00);
    sendFrame(8'h3C, 1'b1, 1'b1);
    rd(3'd0, v); checkEq("R4 ninth set", {7'd0, v[2]}, 8'h01);
    rd(3'd4, v); checkEq("R4 buf 2", v, 8'h3C);

    // R10: no overwrite while ri set
    sendFrame(8'h77, 1'b0, 1'b1);
    rd(3'd4, v); checkEq("R10 buf held", v, 8'h3C);
    rd(3'd0, v); checkEq("R10 ri held", {7'd0, v[0]}, 8'h01);
    checkEq("R10 ninth held", {7'd0, v[2]}, 8'h01);

    // R2: slower tick rate
    wr(3'd0, 8'h00);
    tickDiv = 3;
    sendFrame(8'h96, 1'b1, 1'b1);
    rd(3'd4, v); checkEq("R2 slow tick buf", v, 8'h96);
    rd(3'd0, v); checkEq("R2 slow tick ninth", {7'd0, v[2]}, 8'h01);
    tickDiv = 1;

    // R3: runt start pulse
    wr(3'd0, 8'h00);
    @(negedge clk);
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (64) @(negedge clk);
    rd(3'd0, v); checkEq("R3 runt ignored", {7'd0, v[0]}, 8'h00);
    sendFrame(8'h5A, 1'b0, 1'b1);
    rd(3'd4, v); checkEq("R3 recovery", v, 8'h5A);

    // R5: data character under filter
    wr(3'd2, 8'h53);
    wr(3'd3, 8'hF0);
    wr(3'd0, 8'h20);
    sendFrame(8'h50, 1'b0, 1'b1);
    rd(3'd0, v); checkEq("R5 data dropped", {7'd0, v[0]}, 8'h00);
    rd(3'd4, v); checkEq("R5 buf untouched", v, 8'h5A);

    // R6/R7: exhaustive address sweep
    sa = 8'h53; mk = 8'hF0;
    for (int b = 0; b < 256; b++) begin
      logic [7:0] by;
      logic g, c;
      by = 8'(b);
      g = (((by ^ sa) & mk) == 8'h00);
      c = ((~by & (sa | mk)) == 8'h00);
      wr(3'd0, 8'h20);
      sendFrame(by, 1'b1, 1'b1);
      rd(3'd0, v);
      if (c && !g) checkEq("R7 broadcast", {7'd0, v[0]}, {7'd0, 1'b1});
      else         checkEq("R6 given", {7'd0, v[0]}, {7'd0, g});
      if (g || c) begin
        rd(3'd4, v); checkEq("R6 buf on match", v, by);
      end
    end

    // R6: zero mask and zero address match any byte
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h20);
    sendFrame(8'hC3, 1'b1, 1'b1);
    rd(3'd0, v); checkEq("R6 zero mask", {7'd0, v[0]}, 8'h01);

    // R8/R9: framing error and shared bit
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h00);
    rd(3'd0, v); checkEq("R8 fe clear", {7'd0, v[7]}, 8'h00);
    sendFrame(8'h11, 1'b0, 1'b0);
    rd(3'd0, v); checkEq("R8 fe set", {7'd0, v[7]}, 8'h01);
    checkEq("R4 bad stop still sets ri", {7'd0, v[0]}, 8'h01);
    wr(3'd1, 8'h00);
    rd(3'd0, v); checkEq("R9 mode view", {7'd0, v[7]}, 8'h00);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h80);
    sendFrame(8'h22, 1'b0, 1'b1);
    rd(3'd0, v); checkEq("R8 fe sticky", {7'd0, v[7]}, 8'h01);
    rd(3'd4, v); checkEq("R8 good frame taken", v, 8'h22);
    wr(3'd0, 8'h00);
    rd(3'd0, v); checkEq("R8 fe cleared", {7'd0, v[7]}, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h80);
    rd(3'd0, v); checkEq("R9 mode written", {7'd0, v[7]}, 8'h01);
    wr(3'd1, 8'h01);
    rd(3'd0, v); checkEq("R9 fe unaffected", {7'd0, v[7]}, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule